// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Receiver

This block turns an asynchronous serial line into received characters. A clock-enable tick supplies time at eight times the bit rate, so each bit lasts eight tick-wide time states. Each character has eleven bit times: a low start bit, nine data bits and a high stop bit. The receiver first passes the line through a short synchronizer. It then looks for a high-to-low transition between two ticks. From that transition it takes three samples per bit near the middle of the bit and settles each bit by a two-of-three vote. The time states that are not sampled give margin against a sender whose rate differs slightly.

Software reads the low eight data bits from a data register. The ninth bit lands in a separate single-bit register, which software may also write. When a character completes, a done flag is raised. If the stop bit votes low, an error flag is raised with it. Both flags stay set until software writes the clear strobe. The tick generator, any character queue and any parity check belong to the surrounding logic.

Top module: `uart_vote_rx`

## Requirements
- R1: A character starts on a tick whose synchronized line sample is 0 when the previous tick's idle sample was 1. That start tick is time state 0 of the start bit. After reset, at least one high tick is needed before a start can be recognised.
- R2: Counting ticks from the start tick, each bit is sampled at time states 3, 4 and 5 (tick 8k+3, 8k+4 and 8k+5 for bit k). The bit takes the value held by at least two of the three samples.
- R3: Line values at time states 0, 1, 2, 6 and 7 of a bit have no effect on the result. Because of this, a sender whose bit edges drift by one tick still delivers correct data.
- R4: If the start bit votes 1, the receiver drops the character and goes back to idle. No output changes in that case.
- R5: The nine data bits arrive least significant first. On completion, `rxData` takes data bits 0..7 and `bit9` takes the ninth. `rxData` changes at no other time.
- R6: `bit9Wr` loads `bit9WrVal` into `bit9`. If a capture happens in the same cycle, the received ninth bit wins.
- R7: The capture takes place on the tick at time state 5 of the stop bit (tick 85). That same clock edge sets `rxDone`. `rxDone` stays at 1 until a `doneClr` cycle with no capture, and a capture beats a clear in the same cycle.
- R8: At capture, `frameErr` takes the inverse of the stop-bit vote. A `doneClr` without a capture clears it.
- R9: Reset (`rstN` low, asynchronous) sets `rxData`, `bit9`, `rxDone` and `frameErr` to 0.
- R10: After a capture, the receiver watches for the next start during the rest of the stop bit. A start bit that follows the stop bit immediately is received, provided the stop bit voted 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock enable at eight times the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| doneClr | input | 1 | Software strobe clearing rxDone and frameErr |
| bit9Wr | input | 1 | Software write strobe for the ninth-bit register |
| bit9WrVal | input | 1 | Value written by bit9Wr |
| rxData | output | 8 | Low eight data bits of the last character |
| bit9 | output | 1 | Ninth-bit register |
| rxDone | output | 1 | Character received flag |
| frameErr | output | 1 | Stop bit voted low on the last capture |

## Verification
The hardest states to reach are those where a single character mixes corrupted samples with drifting bit edges, and those where software clears the flag in the very cycle of a capture. The stimulus drives the line one tick at a time. This lets it flip a chosen time state in every data bit, stretch or shrink single bits by one tick, and hold the clear strobe across the exact tick at which the stop bit is voted. Because the behavioural model works tick by tick, it tracks each of these cases without being told where the capture falls.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

  // Control-to-datapath strobes, all qualified by the tick
  typedef struct packed {
    logic takeSample;   // shift the synchronized line into the vote samples
    logic shiftIn;      // push the voted bit into the frame register
    logic capture;      // stop bit voted: publish the character
  } rx_strobe_t;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RECV = 1'b1
  } rx_state_t;

endpackage

// File: rtl/uart_vote_rx_ctrl.sv
module uart_vote_rx_ctrl
  import uart_vote_rx_pkg::*;
#(
  parameter int OVS          = 8,
  parameter int FRAME_DATA   = 9,
  parameter int SAMPLE_FIRST = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineS,
  input  logic       vote,
  output rx_strobe_t strobe
);

  localparam int PHASE_W = $clog2(OVS);
  localparam int BIT_W   = $clog2(FRAME_DATA + 2);
  localparam logic [PHASE_W-1:0] SAMP_A     = PHASE_W'(SAMPLE_FIRST);
  localparam logic [PHASE_W-1:0] SAMP_B     = PHASE_W'(SAMPLE_FIRST + 1);
  localparam logic [PHASE_W-1:0] VOTE_PHASE = PHASE_W'(SAMPLE_FIRST + 2);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(OVS - 1);
  localparam logic [BIT_W-1:0]   START_IDX  = '0;
  localparam logic [BIT_W-1:0]   FIRST_DATA = BIT_W'(1);
  localparam logic [BIT_W-1:0]   LAST_DATA  = BIT_W'(FRAME_DATA);
  localparam logic [BIT_W-1:0]   STOP_IDX   = BIT_W'(FRAME_DATA + 1);

  rx_state_t          state;
  logic [PHASE_W-1:0] phase;
  logic [BIT_W-1:0]   bitIdx;
  logic               prevHigh;

  logic recvTick;
  logic atVote;
  assign recvTick = tick && (state == RX_RECV);
  assign atVote   = recvTick && (phase == VOTE_PHASE);

  always_comb begin
    strobe.takeSample = recvTick && ((phase == SAMP_A) || (phase == SAMP_B));
    strobe.shiftIn    = atVote && (bitIdx >= FIRST_DATA) && (bitIdx <= LAST_DATA);
    strobe.capture    = atVote && (bitIdx == STOP_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      phase    <= '0;
      bitIdx   <= '0;
      prevHigh <= 1'b0;
    end else if (tick) begin
      case (state)
        RX_IDLE: begin
          if (prevHigh && !lineS) begin
            state  <= RX_RECV;
            phase  <= PHASE_W'(1);
            bitIdx <= START_IDX;
          end else begin
            prevHigh <= lineS;
          end
        end
        default: begin
          if ((phase == VOTE_PHASE) && (bitIdx == START_IDX) && vote) begin
            state    <= RX_IDLE;          // false start
            prevHigh <= 1'b1;
          end else if ((phase == VOTE_PHASE) && (bitIdx == STOP_IDX)) begin
            state    <= RX_IDLE;          // re-arm inside the stop bit
            prevHigh <= vote;
          end else begin
            if (phase == LAST_PHASE) begin
              phase  <= '0;
              bitIdx <= bitIdx + BIT_W'(1);
            end else begin
              phase <= phase + PHASE_W'(1);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_vote_rx_dp.sv
module uart_vote_rx_dp
  import uart_vote_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rx_strobe_t        strobe,
  input  logic              doneClr,
  input  logic              bit9Wr,
  input  logic              bit9WrVal,
  output logic              lineS,
  output logic              vote,
  output logic [DATA_W-1:0] rxData,
  output logic              bit9,
  output logic              rxDone,
  output logic              frameErr
);

  localparam int FRAME_DATA = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampA;
  logic                   sampB;
  logic [FRAME_DATA-1:0]  frameSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxLine};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  // two stored samples plus the live one form the vote
  assign vote = (sampA & sampB) | (sampA & lineS) | (sampB & lineS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else if (strobe.takeSample) begin
      sampB <= sampA;
      sampA <= lineS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               frameSr <= '0;
    else if (strobe.shiftIn) frameSr <= {vote, frameSr[FRAME_DATA-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      bit9     <= 1'b0;
      rxDone   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (strobe.capture) begin
        rxData   <= frameSr[DATA_W-1:0];
        bit9     <= frameSr[FRAME_DATA-1];
        rxDone   <= 1'b1;
        frameErr <= ~vote;
      end else begin
        if (bit9Wr) bit9 <= bit9WrVal;
        if (doneClr) begin
          rxDone   <= 1'b0;
          frameErr <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uart_vote_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int OVS          = 8,
  parameter int SAMPLE_FIRST = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxLine,
  input  logic              doneClr,
  input  logic              bit9Wr,
  input  logic              bit9WrVal,
  output logic [DATA_W-1:0] rxData,
  output logic              bit9,
  output logic              rxDone,
  output logic              frameErr
);

  localparam int FRAME_DATA = DATA_W + 1;

  rx_strobe_t ctlStrobe;
  logic       lineS;
  logic       vote;

  uart_vote_rx_ctrl #(
    .OVS(OVS), .FRAME_DATA(FRAME_DATA), .SAMPLE_FIRST(SAMPLE_FIRST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .lineS(lineS), .vote(vote),
    .strobe(ctlStrobe)
  );

  uart_vote_rx_dp #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strobe(ctlStrobe),
    .doneClr(doneClr), .bit9Wr(bit9Wr), .bit9WrVal(bit9WrVal),
    .lineS(lineS), .vote(vote), .rxData(rxData), .bit9(bit9),
    .rxDone(rxDone), .frameErr(frameErr)
  );

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              doneClr,
  input logic              bit9Wr,
  input logic              bit9WrVal,
  input logic [DATA_W-1:0] rxData,
  input logic              bit9,
  input logic              rxDone,
  input logic              frameErr,
  input logic              capture
);

  // R7
  done_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(tick));

  // R7
  capture_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> rxDone);

  // R7
  clear_drops_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneClr && !tick) |=> !rxDone);

  // R8
  ferr_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> rxDone);

  // R6
  bit9_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bit9Wr && !tick) |=> (bit9 == $past(bit9WrVal)));

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(rxData));

endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .doneClr(doneClr),
  .bit9Wr(bit9Wr), .bit9WrVal(bit9WrVal), .rxData(rxData), .bit9(bit9),
  .rxDone(rxDone), .frameErr(frameErr), .capture(ctlStrobe.capture)
);

// File: tb/tb_uart_vote_rx.sv
`timescale 1ns/1ps
module tb_uart_vote_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxLine = 1'b1;
  logic       doneClr = 1'b0;
  logic       bit9Wr = 1'b0;
  logic       bit9WrVal = 1'b0;
  logic [7:0] rxData;
  logic       bit9;
  logic       rxDone;
  logic       frameErr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_vote_rx dut (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine),
    .doneClr(doneClr), .bit9Wr(bit9Wr), .bit9WrVal(bit9WrVal),
    .rxData(rxData), .bit9(bit9), .rxDone(rxDone), .frameErr(frameErr)
  );

  // ---------------- behavioural reference, one step per tick ----------------
  bit       mBusy, mPrev, s0, s1;
  int       mCount;
  bit [8:0] mBits;
  bit [7:0] mData;
  bit       mB9, mDone, mErr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy = 0; mPrev = 0; mCount = 0; mBits = '0;
      mData = '0; mB9 = 0; mDone = 0; mErr = 0;
    end else begin
      bit capNow, capErr, v;
      int pos, idx;
      capNow = 0; capErr = 0;
      if (tick) begin
        if (!mBusy) begin
          if (!rxLine && mPrev) begin mBusy = 1; mCount = 0; end
          else mPrev = rxLine;
        end else begin
          mCount++;
          pos = mCount % 8;
          idx = mCount / 8;
          if (pos == 3) s0 = rxLine;
          if (pos == 4) s1 = rxLine;
          if (pos == 5) begin
            v = (int'(s0) + int'(s1) + int'(rxLine)) >= 2;
            if (idx == 0 && v) begin mBusy = 0; mPrev = 1; end
            else if (idx >= 1 && idx <= 9) mBits[idx-1] = v;
            else if (idx == 10) begin
              capNow = 1; capErr = !v; mBusy = 0; mPrev = v;
            end
          end
        end
      end
      if (bit9Wr) mB9 = bit9WrVal;
      if (doneClr) begin mDone = 0; mErr = 0; end
      if (capNow) begin
        mData = mBits[7:0]; mB9 = mBits[8]; mDone = 1; mErr = capErr;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R5 rxData vs model", rxData, mData);
      check("R6 bit9 vs model", bit9, mB9);
      check("R7 rxDone vs model", rxDone, mDone);
      check("R8 frameErr vs model", frameErr, mErr);
    end
  end

  // ---------------- stimulus ----------------
  task automatic oneTick(input logic v, input logic clr = 0, input logic clrTick = 0,
                         input logic wr = 0, input logic wv = 0);
    @(negedge clk); rxLine = v; tick = 0; doneClr = clr; bit9Wr = wr; bit9WrVal = wv;
    @(negedge clk); doneClr = 0; bit9Wr = 0;
    @(negedge clk);
    @(negedge clk); tick = 1; doneClr = clrTick;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b1);
  endtask

  // data bits flipped at the time states set in mask; jitter varies bit length 7..9
  task automatic sendFrame(input logic [8:0] d, input logic stopV,
                           input logic [7:0] mask = 8'h00, input bit jitter = 0,
                           input bit clrAtCapture = 0);
    for (int k = 0; k <= 10; k++) begin
      int len;
      logic v;
      len = 8;
      if (jitter && (k % 4 == 1)) len = 9;
      if (jitter && (k % 4 == 3)) len = 7;
      v = (k == 0) ? 1'b0 : (k == 10) ? stopV : d[k-1];
      for (int i = 0; i < len; i++) begin
        logic lv;
        lv = v;
        if (k >= 1 && k <= 9 && i < 8) lv = v ^ mask[i];
        oneTick(lv, 1'b0, (clrAtCapture && k == 10 && i == 5));
      end
    end
  endtask

  task automatic clearFlags();
    oneTick(1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check("R9 rxData reset", rxData, 0);
    check("R9 bit9 reset", bit9, 0);
    check("R9 rxDone reset", rxDone, 0);
    check("R9 frameErr reset", frameErr, 0);
    rstN = 1;
    idle(4);

    // R1 R2 R5 R7: plain character
    sendFrame(9'h1A5, 1'b1);
    check("R5 data A5", rxData, 8'hA5);
    check("R5 ninth bit 1", bit9, 1);
    check("R7 done set", rxDone, 1);
    check("R8 no error", frameErr, 0);
    idle(3);
    clearFlags();
    check("R7 done cleared", rxDone, 0);
    check("R5 data held after clear", rxData, 8'hA5);

    // R2: one sampled state corrupted in every data bit
    sendFrame(9'h03C, 1'b1, 8'b0001_0000);
    check("R2 majority corrects state 4", rxData, 8'h3C);
    check("R2 ninth bit 0", bit9, 0);
    clearFlags();
    sendFrame(9'h0C3, 1'b1, 8'b0000_1000);
    check("R2 majority corrects state 3", rxData, 8'hC3);
    clearFlags();

    // R3: unsampled states fully inverted
    sendFrame(9'h15A, 1'b1, 8'b1100_0111);
    check("R3 unsampled states ignored", rxData, 8'h5A);
    check("R3 ninth bit", bit9, 1);
    clearFlags();

    // R3: one-tick drift of bit edges
    sendFrame(9'h0E7, 1'b1, 8'h00, 1);
    check("R3 drift tolerated", rxData, 8'hE7);
    idle(2);
    clearFlags();

    // R4: false start of two low ticks
    oneTick(1'b0); oneTick(1'b0);
    idle(20);
    check("R4 false start no done", rxDone, 0);
    check("R4 false start data kept", rxData, 8'hE7);
    sendFrame(9'h011, 1'b1);
    check("R4 receive after false start", rxData, 8'h11);
    clearFlags();

    // R8: stop bit low
    sendFrame(9'h1F0, 1'b0);
    check("R8 frame error set", frameErr, 1);
    check("R8 done with error", rxDone, 1);
    check("R8 data still captured", rxData, 8'hF0);
    idle(4);
    clearFlags();
    check("R8 error cleared", frameErr, 0);

    // R6: software write and capture override
    oneTick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1);
    check("R6 bit9 written 1", bit9, 1);
    sendFrame(9'h022, 1'b1);
    check("R6 capture overrides bit9", bit9, 0);
    oneTick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(1);
    check("R6 bit9 written again", bit9, 1);
    clearFlags();

    // R7: clear on the capture tick loses
    sendFrame(9'h099, 1'b1, 8'h00, 0, 1);
    check("R7 capture beats clear", rxDone, 1);
    check("R7 data on clear race", rxData, 8'h99);
    clearFlags();

    // R10: back-to-back characters
    sendFrame(9'h1C3, 1'b1);
    sendFrame(9'h03D, 1'b1);
    check("R10 second back-to-back char", rxData, 8'h3D);
    check("R10 second ninth bit", bit9, 0);
    idle(5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog (R1): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule